// File: doc/BRIEF.md
# Idle-Deleting Rate Adaptation Buffer

This block sits between the source of XGMII characters (one 8-bit lane plus its control flag) and the 64b/66b encoder of a burst-mode upstream transmitter. The FEC encoder periodically needs a gap in the character stream while it emits parity. During that gap it raises `fec_insert`. The buffer then stops sending characters downstream and stores what keeps arriving. When `fec_insert` falls, the buffer sends stored characters from its head, one per cycle. It also throws away every idle character that arrives while the backlog is not zero, so the backlog shrinks back to nothing during inter-frame gaps.

When the buffer is empty and no insertion is in progress, characters pass straight through in the same cycle. The `fifo_empty` flag tells the FEC encoder that nothing is held back, which it checks before it turns the laser off. A sticky `overflow` flag records a character that was lost for lack of room. `burst_start` clears the block at the start of each upstream burst. `active` is low while the laser is off or the burst preamble is being sent, and in that state the block is frozen.

Top module: `rate_adapt_fifo`

## Requirements
- R1: After `rst_n` is released, and in the cycle after `burst_start` is high, `fifo_empty` is 1 and `overflow` is 0. A cycle with `burst_start` high produces no output and stores nothing.
- R2: While `fec_insert` is 1, `out_valid` is 0. Each arriving character that is not deleted by R4 is appended to the tail of the buffer.
- R3: While `fec_insert` is 0 and the buffer is non-empty, `out_valid` is 1 and the output is the head of the buffer, in arrival order, one character per cycle.
- R4: An idle character is `in_ctrl`=1 with `in_data`=0x07. When it arrives while the buffer is non-empty, it is discarded and never reaches the output.
- R5: A control character with any value other than 0x07, and any data character, is never discarded while there is room in the buffer.
- R6: While the buffer is empty, `fec_insert` is 0 and `in_valid` is 1, the arriving character appears on the output in the same cycle, idles included.
- R7: `fifo_empty` is 1 exactly when the buffer holds no characters.
- R8: A character that must be stored while the buffer holds DEPTH characters and none leaves in that cycle is lost. `overflow` is set from the next cycle and stays set until reset or `burst_start`.
- R9: While `active` is 0, `out_valid` is 0, arrivals are ignored and the buffer contents stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| burst_start | input | 1 | Synchronous clear at the start of an upstream burst |
| active | input | 1 | High during the data phase of a burst |
| fec_insert | input | 1 | High while the FEC encoder emits parity |
| in_valid | input | 1 | A character arrives this cycle |
| in_ctrl | input | 1 | Arriving character is a control character |
| in_data | input | 8 | Arriving character value |
| out_valid | output | 1 | A character goes to the encoder this cycle |
| out_ctrl | output | 1 | Control flag of the outgoing character |
| out_data | output | 8 | Value of the outgoing character |
| fifo_empty | output | 1 | Buffer holds no characters |
| overflow | output | 1 | Sticky flag: a character was lost for lack of room |

## Verification
The hardest state to reach is a full buffer that receives one more character to be stored. It needs a long insertion window with no idles at all, because idles arriving into a non-empty buffer are deleted. The bench overrides DEPTH to a small value and holds `fec_insert` high while it feeds DEPTH+2 data characters in a row. It then drains the backlog with idles to show that the flag stays set until `burst_start`. The order of the head and the idle-deletion boundary are also exercised: an idle that arrives while the buffer is empty during insertion must be kept, and the next idle must be dropped.

// File: rtl/rafifo_pkg.sv
package rafifo_pkg;

  localparam int unsigned CHAR_W = 8;
  localparam logic [CHAR_W-1:0] IDLE_CODE = 8'h07;

  typedef struct packed {
    logic              ctrl;
    logic [CHAR_W-1:0] data;
  } xchar_t;

  function automatic logic is_idle(input xchar_t c);
    return c.ctrl && (c.data == IDLE_CODE);
  endfunction

endpackage

// File: rtl/rafifo_ctrl.sv
module rafifo_ctrl
  import rafifo_pkg::*;
(
  input  logic   active,
  input  logic   burst_start,
  input  logic   fec_insert,
  input  logic   in_valid,
  input  xchar_t in_char,
  input  logic   empty,
  input  logic   full,
  output logic   pass_thru,
  output logic   do_pop,
  output logic   do_push,
  output logic   drop_idle,
  output logic   ovf_event
);

  logic run;
  logic arr_idle;
  logic keep;
  logic want_push;
  logic can_push;

  always_comb begin
    run       = active && !burst_start;
    arr_idle  = in_valid && is_idle(in_char);
    pass_thru = run && !fec_insert && empty && in_valid;
    do_pop    = run && !fec_insert && !empty;
    keep      = in_valid && !(arr_idle && !empty);
    drop_idle = run && arr_idle && !empty;
    want_push = run && keep && !pass_thru;
    can_push  = !full || do_pop;
    do_push   = want_push && can_push;
    ovf_event = want_push && !can_push;
  end

endmodule

// File: rtl/rafifo_store.sv
module rafifo_store
  import rafifo_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  xchar_t           wchar,
  output xchar_t           rchar,
  output logic [CNT_W-1:0] level,
  output logic             empty,
  output logic             full
);

  localparam bit POW2 = (DEPTH == (1 << PTR_W));

  xchar_t            mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  rd_ptr;
  logic [PTR_W-1:0]  wr_nxt;
  logic [PTR_W-1:0]  rd_nxt;

  generate
    if (POW2) begin : g_wrap_free
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  assign rchar = mem[rd_ptr];
  assign empty = (level == '0);
  assign full  = (level == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wr_ptr] <= wchar;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= wr_nxt;
      if (pop)  rd_ptr <= rd_nxt;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/rate_adapt_fifo.sv
module rate_adapt_fifo
  import rafifo_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       burst_start,
  input  logic       active,
  input  logic       fec_insert,
  input  logic       in_valid,
  input  logic       in_ctrl,
  input  logic [7:0] in_data,
  output logic       out_valid,
  output logic       out_ctrl,
  output logic [7:0] out_data,
  output logic       fifo_empty,
  output logic       overflow
);

  xchar_t           in_char;
  xchar_t           head;
  xchar_t           out_char;
  logic [CNT_W-1:0] level;
  logic             empty;
  logic             full;
  logic             pass_thru;
  logic             do_pop;
  logic             do_push;
  logic             drop_idle;
  logic             ovf_event;
  logic             ovf_q;

  assign in_char = '{ctrl: in_ctrl, data: in_data};

  rafifo_ctrl u_ctrl (
    .active      (active),
    .burst_start (burst_start),
    .fec_insert  (fec_insert),
    .in_valid    (in_valid),
    .in_char     (in_char),
    .empty       (empty),
    .full        (full),
    .pass_thru   (pass_thru),
    .do_pop      (do_pop),
    .do_push     (do_push),
    .drop_idle   (drop_idle),
    .ovf_event   (ovf_event)
  );

  rafifo_store #(.DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (burst_start),
    .push  (do_push),
    .pop   (do_pop),
    .wchar (in_char),
    .rchar (head),
    .level (level),
    .empty (empty),
    .full  (full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ovf_q <= 1'b0;
    else if (burst_start) ovf_q <= 1'b0;
    else if (ovf_event)   ovf_q <= 1'b1;
  end

  assign out_char   = do_pop ? head : in_char;
  assign out_valid  = pass_thru || do_pop;
  assign out_ctrl   = out_char.ctrl;
  assign out_data   = out_char.data;
  assign fifo_empty = empty;
  assign overflow   = ovf_q;

endmodule

// File: rtl/rate_adapt_fifo_chk.sv
module rate_adapt_fifo_chk #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             burst_start,
  input logic             active,
  input logic             fec_insert,
  input logic             in_valid,
  input logic             in_ctrl,
  input logic [7:0]       in_data,
  input logic             out_valid,
  input logic             out_ctrl,
  input logic [7:0]       out_data,
  input logic             fifo_empty,
  input logic             overflow,
  input logic [CNT_W-1:0] level,
  input logic             drop_idle
);

  AST_INSERT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    fec_insert |-> !out_valid); // R2

  AST_PASS_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !burst_start && !fec_insert && fifo_empty && in_valid)
    |-> (out_valid && out_ctrl == in_ctrl && out_data == in_data)); // R6

  AST_IDLE_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !burst_start && !fec_insert && !fifo_empty && in_valid
     && in_ctrl && in_data == 8'h07)
    |=> (level == CNT_W'($past(level) - 1'b1))); // R4

  AST_IDLE_DROP_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    drop_idle |-> (in_ctrl && in_data == 8'h07 && !fifo_empty)); // R4

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !burst_start) |=> overflow); // R8

  AST_BURST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> (fifo_empty && !overflow)); // R1

  AST_INACTIVE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !burst_start) |=> $stable(level)); // R9

  AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !out_valid); // R9

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_W'(DEPTH)); // R8

endmodule

bind rate_adapt_fifo rate_adapt_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .burst_start (burst_start),
  .active      (active),
  .fec_insert  (fec_insert),
  .in_valid    (in_valid),
  .in_ctrl     (in_ctrl),
  .in_data     (in_data),
  .out_valid   (out_valid),
  .out_ctrl    (out_ctrl),
  .out_data    (out_data),
  .fifo_empty  (fifo_empty),
  .overflow    (overflow),
  .level       (level),
  .drop_idle   (drop_idle)
);

// File: tb/test_rate_adapt_fifo.sv
module test_rate_adapt_fifo;

  localparam int unsigned DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       burst_start = 1'b0;
  logic       active = 1'b0;
  logic       fec_insert = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ctrl = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       out_valid;
  logic       out_ctrl;
  logic [7:0] out_data;
  logic       fifo_empty;
  logic       overflow;

  always #2 clk = ~clk;

  rate_adapt_fifo #(.DEPTH(DEPTH)) i_rate_adapt_fifo (
    .clk, .rst_n, .burst_start, .active, .fec_insert, .in_valid,
    .in_ctrl, .in_data, .out_valid, .out_ctrl, .out_data,
    .fifo_empty, .overflow
  );

  typedef struct {
    bit         ev;
    logic [8:0] ech;
    bit         eempty;
    bit         eovf;
    string      tag;
  } exp_t;

  exp_t       scb[$];
  logic [8:0] mq[$];
  bit         movf = 1'b0;
  int         total = 0;
  int         bad = 0;
  bit         finished = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and predict its outcome
  task automatic step(input bit v, input bit c, input logic [7:0] d,
                      input bit ins, input bit act, input bit bs,
                      input string tag);
    exp_t e;
    bit   idle;
    bit   emp;
    @(negedge clk);
    burst_start = bs; active = act; fec_insert = ins;
    in_valid = v; in_ctrl = c; in_data = d;
    e.eempty = (mq.size() == 0);
    e.eovf   = movf;
    e.ev     = 1'b0;
    e.ech    = '0;
    e.tag    = tag;
    idle     = v && c && (d == 8'h07);
    emp      = (mq.size() == 0);
    if (bs) begin
      mq.delete();
      movf = 1'b0;
    end else if (act) begin
      if (!ins && emp && v) begin
        e.ev = 1'b1; e.ech = {c, d};
      end else begin
        if (!ins && !emp) begin
          e.ev = 1'b1; e.ech = mq.pop_front();
        end
        if (v && !(idle && !emp)) begin
          if (mq.size() < DEPTH) mq.push_back({c, d});
          else movf = 1'b1;
        end
      end
    end
    scb.push_back(e);
  endtask

  // monitor: compare the ports against the predicted outcome
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (scb.size() > 0) begin
        exp_t e;
        e = scb.pop_front();
        check(out_valid == e.ev, e.tag, "out_valid", 9'(out_valid), 9'(e.ev));
        if (e.ev)
          check({out_ctrl, out_data} == e.ech, e.tag, "char",
                {out_ctrl, out_data}, e.ech);
        check(fifo_empty == e.eempty, "R7", "fifo_empty",
              9'(fifo_empty), 9'(e.eempty));
        check(overflow == e.eovf, "R8", "overflow", 9'(overflow), 9'(e.eovf));
      end
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    step(0, 0, 8'h00, 0, 0, 0, "R1");
    step(0, 0, 8'h00, 0, 0, 0, "R1");
    // R6: pass-through while empty, idles included
    step(1, 0, 8'h11, 0, 1, 0, "R6");
    step(1, 1, 8'h07, 0, 1, 0, "R6");
    step(1, 1, 8'hFB, 0, 1, 0, "R6");
    step(1, 0, 8'h22, 0, 1, 0, "R6");
    // R2: insertion window; first idle kept (empty), second dropped (R4)
    step(1, 1, 8'h07, 1, 1, 0, "R2");
    step(1, 0, 8'hA1, 1, 1, 0, "R2");
    step(1, 1, 8'h07, 1, 1, 0, "R4");
    step(1, 0, 8'hA2, 1, 1, 0, "R2");
    // R3 drain in order; R4 idles deleted; R5 other control kept
    step(1, 1, 8'h07, 0, 1, 0, "R3");
    step(1, 1, 8'hFD, 0, 1, 0, "R5");
    step(0, 0, 8'h00, 0, 1, 0, "R3");
    step(1, 1, 8'h07, 0, 1, 0, "R4");
    step(1, 1, 8'h07, 0, 1, 0, "R4");
    step(1, 1, 8'h07, 0, 1, 0, "R6");
    // R9: inactive freezes state and ignores arrivals
    step(1, 0, 8'hA3, 1, 1, 0, "R2");
    step(1, 0, 8'hA4, 1, 1, 0, "R2");
    for (int i = 0; i < 3; i++) step(1, 0, 8'hB0 + 8'(i), 0, 0, 0, "R9");
    step(1, 1, 8'h07, 0, 1, 0, "R9");
    step(1, 1, 8'h07, 0, 1, 0, "R9");
    step(1, 1, 8'h07, 0, 1, 0, "R9");
    // R8: fill past DEPTH during insertion, flag stays through drain
    for (int i = 0; i < DEPTH + 2; i++) step(1, 0, 8'hC0 + 8'(i), 1, 1, 0, "R8");
    for (int i = 0; i < DEPTH + 1; i++) step(1, 1, 8'h07, 0, 1, 0, "R8");
    // R1: burst_start clears flag and backlog
    step(1, 0, 8'hD1, 1, 1, 0, "R2");
    step(1, 0, 8'hD2, 1, 1, 0, "R2");
    step(1, 0, 8'hD3, 0, 1, 1, "R1");
    step(1, 0, 8'hE1, 0, 1, 0, "R1");
    step(0, 0, 8'h00, 0, 1, 0, "R1");
    step(0, 0, 8'h00, 0, 1, 0, "R1");
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule